// File: doc/BRIEF.md
# EX-stage operand forwarding unit

This block picks the two ALU operands for the instruction now in the execute stage of an in-order pipeline. Each operand comes from one of three places: the register-file value that was read in decode and latched into the decode/execute register, the ALU result of the instruction one stage ahead (held in the execute/memory register), or the value about to be written back (held in the memory/writeback register). When an instruction needs a result that the one just before it produced, it gets that result through this bypass and does not stall. The register-file read in decode still returns the old value, and this unit replaces it at the ALU input.

The unit compares the two source register numbers of the execute-stage instruction with the destination numbers of the two older instructions, using each producer's register-write enable. The newer producer wins when both match. Register 0 is never forwarded. A load's data reaches the memory/writeback register only after the load has finished its memory stage. Keeping a load from its consumer in the cycle right after it is a job for the stall logic, which sits outside this block. The unit is purely combinational, so its outputs follow its inputs within the same cycle. Its pins are plain pipeline control and data with no handshake, because the surrounding pipeline registers already set the timing.

Top module: `fwd_unit`

## Requirements
- R1: When neither producer qualifies for a source register, that operand's select is 00 and the operand equals its register-file value.
- R2: When the execute/memory producer has its write enable high and its destination equals a nonzero source register, that operand's select is 10 and the operand equals the execute/memory data.
- R3: When only the memory/writeback producer has its write enable high and its destination equals a nonzero source register, that operand's select is 01 and the operand equals the writeback data.
- R4: When both producers qualify for the same source register, the execute/memory value is chosen (select 10).
- R5: A source register number of 0 is never forwarded (select 00), even when a producer with its write enable high names register 0.
- R6: A producer whose write enable is low is never a forwarding source. A match on it alone gives select 00. If the other producer also matches, the other producer supplies the value.
- R7: Operand A (from rs) and operand B (from rt) are resolved independently, so in one cycle they may take different selects and different sources.
- R8: Select code 11 is never produced.
- R9: Selects and operands respond combinationally: a change on any data or number input shows up at the outputs within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_num | input | 5 | rs number of the execute-stage instruction |
| src_b_num | input | 5 | rt number of the execute-stage instruction |
| rf_a_val | input | 32 | Register-file value latched for operand A |
| rf_b_val | input | 32 | Register-file value latched for operand B |
| exm_dst_num | input | 5 | Destination number in the execute/memory register |
| exm_wr_en | input | 1 | Register-write enable of the execute/memory producer |
| exm_val | input | 32 | ALU result in the execute/memory register |
| mwb_dst_num | input | 5 | Destination number in the memory/writeback register |
| mwb_wr_en | input | 1 | Register-write enable of the memory/writeback producer |
| mwb_val | input | 32 | Writeback value in the memory/writeback register |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding as sel_a |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |

## Verification
The select-logic assertions assume that every input is a settled two-state value when it is evaluated, and that the stall logic outside the block has already kept a load away from a consumer that is one stage behind it. The bench drives all inputs together on the falling clock edge, uses no X or Z values, and reads the outputs a short time later. It steps through a table of register-number patterns that covers a match at each stage, matches at both stages, register 0, and cleared write enables. It then runs directed cases that change only the data values.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MWB = 2'b01,
    SRC_EXM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic [RW-1:0] src_num,
  input  logic [RW-1:0] exm_dst,
  input  logic          exm_we,
  input  logic [RW-1:0] mwb_dst,
  input  logic          mwb_we,
  output fwd_src_e      sel
);
  logic exm_hit;
  logic mwb_hit;
  logic src_live;

  always_comb begin
    src_live = (src_num != '0);
    exm_hit  = exm_we && src_live && (exm_dst == src_num);
    mwb_hit  = mwb_we && src_live && (mwb_dst == src_num);
    if (exm_hit)      sel = SRC_EXM;
    else if (mwb_hit) sel = SRC_MWB;
    else              sel = SRC_RF;
  end

  always_comb begin
    // R8: the unused code never appears
    a_r8_no_code11: assert (sel != 2'b11);
    // R5: register 0 stays on the register-file path
    a_r5_zero_not_fwd: assert (src_num != '0 || sel == SRC_RF);
    // R6: a source stage is always an enabled writer of this register
    a_r6_we_required: assert ((sel != SRC_EXM || (exm_we && exm_dst == src_num)) &&
                              (sel != SRC_MWB || (mwb_we && mwb_dst == src_num)));
    // R4: writeback is chosen only when execute/memory cannot supply
    a_r4_newer_wins: assert (sel != SRC_MWB || !(exm_we && exm_dst == src_num));
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  fwd_src_e      sel,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] exm_val,
  input  logic [DW-1:0] mwb_val,
  output logic [DW-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SRC_EXM: opnd = exm_val;
      SRC_MWB: opnd = mwb_val;
      default: opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int DW = DATA_W
) (
  input  logic [RW-1:0] src_a_num,
  input  logic [RW-1:0] src_b_num,
  input  logic [DW-1:0] rf_a_val,
  input  logic [DW-1:0] rf_b_val,
  input  logic [RW-1:0] exm_dst_num,
  input  logic          exm_wr_en,
  input  logic [DW-1:0] exm_val,
  input  logic [RW-1:0] mwb_dst_num,
  input  logic          mwb_wr_en,
  input  logic [DW-1:0] mwb_val,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  localparam int NOPND = 2;

  logic [RW-1:0] src_num [NOPND];
  logic [DW-1:0] rf_val  [NOPND];
  logic [DW-1:0] res     [NOPND];
  fwd_src_e      sel     [NOPND];

  assign src_num[0] = src_a_num;
  assign src_num[1] = src_b_num;
  assign rf_val[0]  = rf_a_val;
  assign rf_val[1]  = rf_b_val;

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    fwd_select #(.RW(RW)) u_sel (
      .src_num (src_num[i]),
      .exm_dst (exm_dst_num),
      .exm_we  (exm_wr_en),
      .mwb_dst (mwb_dst_num),
      .mwb_we  (mwb_wr_en),
      .sel     (sel[i])
    );
    fwd_mux #(.DW(DW)) u_mux (
      .sel     (sel[i]),
      .rf_val  (rf_val[i]),
      .exm_val (exm_val),
      .mwb_val (mwb_val),
      .opnd    (res[i])
    );
  end

  assign sel_a  = sel[0];
  assign sel_b  = sel[1];
  assign opnd_a = res[0];
  assign opnd_b = res[1];
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  src_a_num, src_b_num, exm_dst_num, mwb_dst_num;
  logic        exm_wr_en, mwb_wr_en;
  logic [31:0] rf_a_val, rf_b_val, exm_val, mwb_val;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  fwd_unit u_dut (.*);

  typedef struct packed {
    logic [4:0] ra, rb, xd;
    logic       xw;
    logic [4:0] wd;
    logic       ww;
    logic [1:0] ea, eb;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00}, // R1
    '{5'd3,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b10, 2'b00}, // R2
    '{5'd2,  5'd3,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b10}, // R2
    '{5'd4,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b01, 2'b00}, // R3
    '{5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'b10, 2'b10}, // R4
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R5
    '{5'd0,  5'd6,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R5
    '{5'd7,  5'd7,  5'd7,  1'b0, 5'd7,  1'b1, 2'b01, 2'b01}, // R6
    '{5'd7,  5'd8,  5'd7,  1'b0, 5'd8,  1'b0, 2'b00, 2'b00}, // R6
    '{5'd9,  5'd10, 5'd10, 1'b1, 5'd9,  1'b1, 2'b01, 2'b10}, // R7
    '{5'd31, 5'd31, 5'd31, 1'b1, 5'd30, 1'b1, 2'b10, 2'b10}, // R2 top register
    '{5'd30, 5'd31, 5'd31, 1'b1, 5'd30, 1'b1, 2'b01, 2'b10}  // R7
  };

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
    if (s == 2'b10)      return exm_val;
    else if (s == 2'b01) return mwb_val;
    else                 return rf;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_both(input string req, input logic [1:0] ea, input logic [1:0] eb);
    check(req, {30'd0, sel_a}, {30'd0, ea});
    check(req, {30'd0, sel_b}, {30'd0, eb});
    check(req, opnd_a, pick(ea, rf_a_val));
    check(req, opnd_b, pick(eb, rf_b_val));
    check("R8", {31'd0, (sel_a == 2'b11) || (sel_b == 2'b11)}, 32'd0);
  endtask

  initial begin
    src_a_num = '0; src_b_num = '0; exm_dst_num = '0; mwb_dst_num = '0;
    exm_wr_en = 1'b0; mwb_wr_en = 1'b0;
    rf_a_val = 32'hA0A0_000A; rf_b_val = 32'hB5B5_000B;
    exm_val  = 32'hE0E0_0001; mwb_val  = 32'hC0C0_0002;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_both("R1 reset state", 2'b00, 2'b00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_a_num = VEC[i].ra; src_b_num = VEC[i].rb;
      exm_dst_num = VEC[i].xd; exm_wr_en = VEC[i].xw;
      mwb_dst_num = VEC[i].wd; mwb_wr_en = VEC[i].ww;
      #1;
      check_both($sformatf("vector %0d", i), VEC[i].ea, VEC[i].eb);
    end

    // R9: data-only change follows with no clock edge in between
    @(negedge clk);
    src_a_num = 5'd12; src_b_num = 5'd13;
    exm_dst_num = 5'd12; exm_wr_en = 1'b1;
    mwb_dst_num = 5'd13; mwb_wr_en = 1'b1;
    #1;
    exm_val = 32'h1234_5678; mwb_val = 32'h9ABC_DEF0;
    #0.5;
    check("R9 opnd_a", opnd_a, 32'h1234_5678);
    check("R9 opnd_b", opnd_b, 32'h9ABC_DEF0);

    // R1: register-file value passes through when unmatched
    rf_b_val = 32'h0F0F_F0F0; src_b_num = 5'd14;
    #0.5;
    check("R1 rf pass", opnd_b, 32'h0F0F_F0F0);

    // R6: dropping the newer enable hands operand A to writeback
    mwb_dst_num = 5'd12; exm_wr_en = 1'b0;
    #0.5;
    check("R6 fallback", {30'd0, sel_a}, 32'd1);
    check("R6 fallback data", opnd_a, 32'h9ABC_DEF0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule